// File: doc/BRIEF.md
# Grouped Auto-Increment Control Register Bank

This block holds fourteen 8-bit control registers, numbered 0 to 13, and one alternate register that shares address 11. A host writes them through a byte-serial link, which appears here as two strobes. A start strobe carries the register address. Each data strobe after it writes one byte. After every data byte an internal pointer moves to the next address, but only inside fixed groups. Addresses 0 to 3 form a chain that ends at 3, and address 3 never advances. Addresses 4 to 7 form one group. Addresses 8 up to a parameterised last register form another group. At the end of a group the pointer stays where it is.

Reads are combinational on a separate address port. At address 11, bit 7 of register 0 selects either the primary register or the alternate one, for reads and for writes.

After reset, a clear sequencer fills an external character memory. It issues one write strobe per clock. Every location receives the space code. One location, chapter 0 row 0 column 7, receives a different code. While the sequencer runs, the block shows busy and ignores host strobes.

Top module: `ctl_regbank`

## Requirements
- R1: After a data byte written at address 0 the pointer moves to 1; after 1 it moves to 2; after 2 it moves to 3.
- R2: At address 3 the pointer does not advance, so successive data bytes all land in register 3.
- R3: Within addresses 4 to 7 the pointer advances by one after each data byte. At 7 it holds and does not move to 8.
- R4: Within addresses 8 to LAST_REG (12 or 13) the pointer advances by one after each data byte and holds at LAST_REG. When LAST_REG is 12, register 13 can be reached only by a start strobe, and the pointer holds there.
- R5: After reset, registers 1, 5 and 6 read 0x03. All other registers and the alternate register read 0x00.
- R6: Address 11 reads and writes the alternate register when bit 7 of register 0 is 1, and the primary register 11 when that bit is 0.
- R7: Inactive bits are forced to 0 on write and read as 0. These are register 2 bit 3, register 3 bits 7:5 and register 13 bits 7:4. Addresses 14 and 15 read 0x00, and writes to them change nothing.
- R8: After reset, busy is 1 and one memory write is issued per clock for addresses 0 to DEPTH-1 in order, where DEPTH = CHAPTERS*ROWS*COLS. Every location receives 0x20 except address 7 (chapter 0, row 0, column 7), which receives 0x07. Busy then falls.
- R9: Start and data strobes that arrive while busy is 1 change neither the pointer nor any register.
- R10: A start strobe loads the pointer from bits 3:0 of the byte and writes no register. If a start strobe and a data strobe occur together, the start strobe wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Address byte strobe |
| valid_i | input | 1 | Data byte strobe |
| data_i | input | 8 | Received byte |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| busy_o | output | 1 | Clear sequencer running |
| mem_we_o | output | 1 | Display memory write strobe |
| mem_addr_o | output | AW | Display memory address |
| mem_data_o | output | 8 | Display memory write data |

## Verification
The checker watches the following on every cycle:
- the pointer holds at address 3 and at the top of each group;
- a strobe during busy leaves the pointer unchanged;
- the clear address steps by one and busy ends at the last location and stays low;
- inactive bits read as zero.

Only the bench scenarios can show the rest:
- the stored contents after mixed write bursts;
- the reset values;
- the alternate-register selection for reads and writes;
- start-over-data precedence;
- the exact fill code at each memory location.

// File: rtl/ctl_regbank.sv
`timescale 1ns/1ps
module ctl_regbank #(
  parameter int LAST_REG = 12,
  parameter int CHAPTERS = 2,
  parameter int ROWS = 25,
  parameter int COLS = 40,
  localparam int AW = $clog2(CHAPTERS*ROWS*COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          valid_i,
  input  logic [7:0]    data_i,
  input  logic [3:0]    rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic          busy_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_data_o
);
  localparam int DEPTH = CHAPTERS*ROWS*COLS;
  localparam int NREG = 14;
  localparam logic [AW-1:0] MARK_ADDR = AW'(7);

  function automatic logic [7:0] live_bits(int i);
    case (i)
      2:       return 8'hF7;
      3:       return 8'h1F;
      13:      return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [3:0] step(logic [3:0] p);
    if (p < 4'd3) return p + 4'd1;
    if (p >= 4'd4 && p < 4'd7) return p + 4'd1;
    if (p >= 4'd8 && p < 4'(LAST_REG)) return p + 4'd1;
    return p;
  endfunction

  logic [7:0]    regs [NREG];
  logic [7:0]    alt11;
  logic [3:0]    ptr;
  logic [AW-1:0] cnt;
  logic          busy;

  wire use_alt = regs[0][7];
  wire wr_en   = valid_i && !start_i && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (!busy) begin
      if (start_i) ptr <= data_i[3:0];
      else if (valid_i) ptr <= step(ptr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++)
        regs[i] <= (i == 1 || i == 5 || i == 6) ? 8'h03 : 8'h00;
      alt11 <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NREG; i++)
        if (ptr == 4'(i) && !(i == 11 && use_alt))
          regs[i] <= data_i & live_bits(i);
      if (ptr == 4'd11 && use_alt)
        alt11 <= data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr_i == 4'(i)) rd_data_o = regs[i];
    if (rd_addr_i == 4'd11 && use_alt) rd_data_o = alt11;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == AW'(DEPTH-1)) busy <= 1'b0;
      else cnt <= cnt + 1'b1;
    end
  end

  assign busy_o     = busy;
  assign mem_we_o   = busy;
  assign mem_addr_o = cnt;
  assign mem_data_o = (cnt == MARK_ADDR) ? 8'h07 : 8'h20;
endmodule

module ctl_regbank_chk #(
  parameter int LAST_REG = 12,
  parameter int AW = 11,
  parameter int DEPTH = 2000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          valid_i,
  input logic          busy_o,
  input logic [3:0]    ptr,
  input logic [3:0]    rd_addr_i,
  input logic [7:0]    rd_data_o,
  input logic [AW-1:0] mem_addr_o
);
  // R2
  ptr3_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == 4'd3 && valid_i && !start_i && !busy_o) |=> ptr == 4'd3);
  // R3
  grp_a_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == 4'd7 && valid_i && !start_i && !busy_o) |=> ptr == 4'd7);
  // R4
  grp_b_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == 4'(LAST_REG) && valid_i && !start_i && !busy_o) |=> ptr == 4'(LAST_REG));
  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && (valid_i || start_i)) |=> $stable(ptr));
  // R8
  clear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && mem_addr_o != AW'(DEPTH-1)) |=> mem_addr_o == $past(mem_addr_o) + 1'b1);
  // R8
  clear_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && mem_addr_o == AW'(DEPTH-1)) |=> !busy_o);
  // R8
  clear_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> !busy_o);
  // R7
  dead_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i == 4'd3 |-> rd_data_o[7:5] == 3'b0) and
    (rd_addr_i == 4'd13 |-> rd_data_o[7:4] == 4'b0) and
    (rd_addr_i >= 4'd14 |-> rd_data_o == 8'h00));
endmodule

bind ctl_regbank ctl_regbank_chk #(.LAST_REG(LAST_REG), .AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i), .busy_o(busy_o),
  .ptr(ptr), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .mem_addr_o(mem_addr_o));

// File: tb/ctl_regbank_test.sv
`timescale 1ns/1ps
module ctl_regbank_test;
  localparam int DEPTH = 2000;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0, start_i = 0, valid_i = 0;
  logic [7:0] data_i = 0;
  logic [3:0] rd_addr_i = 0;
  logic [7:0] rd_data_o, mem_data_o;
  logic busy_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  int checks = 0, errors = 0;
  int mem_writes = 0, mem_bad = 0;

  always #2 clk = ~clk;

  ctl_regbank uut (.clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
    .data_i(data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .busy_o(busy_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o));

  always @(negedge clk) if (rst_n && mem_we_o) begin
    if (int'(mem_addr_o) != mem_writes) mem_bad++;
    if (mem_data_o != ((mem_writes == 7) ? 8'h07 : 8'h20)) mem_bad++;
    mem_writes++;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(logic st, logic vl, logic [7:0] d);
    @(negedge clk); start_i = st; valid_i = vl; data_i = d;
    @(negedge clk); start_i = 0; valid_i = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    rd_addr_i = a; #0.5; v = rd_data_o;
  endtask

  task automatic expect_reg(string req, logic [3:0] a, logic [7:0] e);
    logic [7:0] v;
    rd(a, v);
    check(req, v, e);
  endtask

  task automatic t_reset_and_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R8 busy after reset", busy_o, 1);
    for (int a = 0; a < 16; a++)
      expect_reg("R5 reset value", 4'(a), (a == 1 || a == 5 || a == 6) ? 8'h03 : 8'h00);
    strobe(1, 0, 8'h04);
    strobe(0, 1, 8'hFF);
    strobe(1, 1, 8'h00);
    while (busy_o) @(negedge clk);
    check("R8 write count", mem_writes, DEPTH);
    check("R8 order and fill code", mem_bad, 0);
    expect_reg("R9 reg4 untouched during busy", 4'd4, 8'h00);
    expect_reg("R9 reg0 untouched during busy", 4'd0, 8'h00);
  endtask

  task automatic t_low_chain();
    strobe(1, 0, 8'h00);
    strobe(0, 1, 8'h11);
    strobe(0, 1, 8'h22);
    strobe(0, 1, 8'h3C);
    strobe(0, 1, 8'h44);
    strobe(0, 1, 8'hF5);
    expect_reg("R1 reg0", 4'd0, 8'h11);
    expect_reg("R1 reg1", 4'd1, 8'h22);
    expect_reg("R7 reg2 bit3 masked", 4'd2, 8'h34);
    expect_reg("R2 reg3 last byte masked", 4'd3, 8'h15);
    expect_reg("R2 reg4 not reached", 4'd4, 8'h00);
  endtask

  task automatic t_group_a();
    strobe(1, 0, 8'h04);
    for (int i = 0; i < 5; i++) strobe(0, 1, 8'hA1 + 8'(i));
    expect_reg("R3 reg4", 4'd4, 8'hA1);
    expect_reg("R3 reg5", 4'd5, 8'hA2);
    expect_reg("R3 reg6", 4'd6, 8'hA3);
    expect_reg("R3 reg7 holds", 4'd7, 8'hA5);
    expect_reg("R3 reg8 not crossed", 4'd8, 8'h00);
  endtask

  task automatic t_group_b();
    strobe(1, 0, 8'h08);
    for (int i = 0; i < 6; i++) strobe(0, 1, 8'hB0 + 8'(i));
    expect_reg("R4 reg8", 4'd8, 8'hB0);
    expect_reg("R4 reg11", 4'd11, 8'hB3);
    expect_reg("R4 reg12 holds", 4'd12, 8'hB5);
    expect_reg("R4 reg13 not crossed", 4'd13, 8'h00);
    strobe(1, 0, 8'h0D);
    strobe(0, 1, 8'hC5);
    strobe(0, 1, 8'hC6);
    expect_reg("R7 reg13 masked, R4 holds at 13", 4'd13, 8'h06);
    expect_reg("R4 reg12 unchanged", 4'd12, 8'hB5);
  endtask

  task automatic t_alternate();
    strobe(1, 0, 8'h00);
    strobe(0, 1, 8'h80);
    strobe(1, 0, 8'h0B);
    strobe(0, 1, 8'h5A);
    expect_reg("R6 alternate read", 4'd11, 8'h5A);
    strobe(1, 0, 8'h00);
    strobe(0, 1, 8'h00);
    expect_reg("R6 primary kept", 4'd11, 8'hB3);
  endtask

  task automatic t_dead_and_start();
    strobe(1, 0, 8'h0E);
    strobe(0, 1, 8'hFF);
    strobe(0, 1, 8'hFF);
    expect_reg("R7 addr14 reads 0", 4'd14, 8'h00);
    expect_reg("R7 addr15 reads 0", 4'd15, 8'h00);
    expect_reg("R7 reg13 unchanged", 4'd13, 8'h06);
    strobe(1, 0, 8'hF3);
    strobe(1, 1, 8'h06);
    expect_reg("R10 start wins, reg3 kept", 4'd3, 8'h15);
    strobe(0, 1, 8'h77);
    expect_reg("R10 pointer loaded to 6", 4'd6, 8'h77);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_and_clear();
    t_low_chain();
    t_group_a();
    t_group_b();
    t_alternate();
    t_dead_and_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule